// File: doc/BRIEF.md
# Master-Mode Serial Output Engine for a Sampling Converter

This block is the digital output stage of a 16-bit sampling converter that runs its serial port as the clock master. A one-cycle start strobe begins a conversion of fixed length, `CONV_CYCLES` system clocks. When the conversion ends, the block captures the word presented on `sample_data`, which a behavioural converter model drives. It then sends a word to the host over three lines: a serial clock that the block generates itself, a frame signal, and serial data sent MSB first.

The `read_mode` input selects one of two read modes. It is sampled when a start is accepted.
- **Mode 0:** the block shifts out the new result once its own conversion has finished. `busy` stays high until the last bit has left the block.
- **Mode 1:** the block shifts out the previously captured result while the new conversion is still running. `busy` spans only the conversion.

Two static inputs invert the polarity of the serial clock and of the frame signal. The system clock is divided so that each bit lasts `4*QTR` system clocks. The clock rises a quarter of the way into the bit and falls at three quarters. The data line therefore holds steady across both clock edges.

Top module: `adc_serial_master`

## Requirements
- R1: A `conv_start` pulse sampled while `busy` is low sets `busy` high from the next cycle.
- R2: A `conv_start` pulse sampled while `busy` is high has no effect. The `busy` length, the read mode in use and the data sent are unchanged.
- R3: In mode 0 (`read_mode`=0 at the start), the word on `sample_data` is captured at the end of the conversion and then sent. `busy` stays high for `CONV_CYCLES + 16*4*QTR` cycles and falls only after the 16th bit.
- R4: In mode 1 (`read_mode`=1 at the start), the frame begins right after the start is accepted and carries the word captured by the previous conversion (zero after reset). `busy` stays high for exactly `CONV_CYCLES` cycles, and the frame ends before the conversion does.
- R5: A frame carries exactly 16 bits, MSB first, with exactly one serial clock pulse per bit.
- R6: Each bit lasts `4*QTR` system clocks. The serial clock is high for the middle `2*QTR` of them. `sdout` stays constant from the rising edge to the falling edge of each pulse.
- R7: The frame signal is active for exactly the duration of the frame, and only while `busy` is high.
- R8: `sclk_inv`=1 inverts `sclk` and `sync_inv`=1 inverts `sync`. Neither changes the data or the timing.
- R9: Outside a frame, `sdout` is 0 and `sclk` rests at its idle level, which is 0 XOR `sclk_inv`.
- R10: The captured result changes only at the end of a conversion. Changes on `sample_data` at other times never reach the serial data.
- R11: After reset, `busy`=0, `sdout`=0, `sync`=`sync_inv` and `sclk`=`sclk_inv`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_start | input | 1 | One-cycle conversion start strobe |
| sample_data | input | 16 | Result word from the converter model |
| read_mode | input | 1 | 0: read after conversion, 1: read previous result during conversion |
| sclk_inv | input | 1 | Invert the generated serial clock |
| sync_inv | input | 1 | Invert the frame signal |
| busy | output | 1 | Conversion (and mode-0 readout) in progress |
| sclk | output | 1 | Generated serial clock |
| sync | output | 1 | Frame signal, active while serial data is valid |
| sdout | output | 1 | Serial data, MSB first |

## Verification
The bench sends a second start in the middle of a conversion, with the opposite read mode. A block that accepted it would restart its counter and stretch `busy`, or would switch modes and send a different word. It scrambles `sample_data` right after each capture, which exposes a block that shifts straight from the input rather than from the captured register. It alternates the two modes, so that a block that sent the new word in mode 1, or released `busy` at the end of the conversion in mode 0, shows a wrong word or a wrong `busy` length. It also samples each bit at both clock edges and repeats a mixed-mode run with both polarities inverted, which catches data changing inside a pulse and idle levels that ignore the inversion.

// File: rtl/adc_ser_pkg.sv
package adc_ser_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CONV  = 2'd1,
    ST_SHIFT = 2'd2
  } ctl_state_e;
endpackage

// File: rtl/adc_rst_sync.sv
module adc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_n_sync = sync_q;
endmodule

// File: rtl/adc_sclk_gen.sv
module adc_sclk_gen #(
  parameter int QTR = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  output logic sclk_raw,
  output logic bit_end
);
  localparam int BIT_CYC = 4 * QTR;
  localparam int PH_W    = $clog2(BIT_CYC);
  localparam logic [PH_W-1:0] PH_RISE = PH_W'(QTR);
  localparam logic [PH_W-1:0] PH_FALL = PH_W'(3 * QTR);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(BIT_CYC - 1);

  logic [PH_W-1:0] phase_q;
  logic [PH_W-1:0] phase_n;
  logic            phase_en;

  assign phase_en = restart | run;

  always_comb begin
    phase_n = phase_q;
    if (restart) begin
      phase_n = '0;
    end else if (run) begin
      if (phase_q == PH_LAST) phase_n = '0;
      else                    phase_n = phase_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        phase_q <= '0;
    else if (phase_en) phase_q <= phase_n;
  end

  assign sclk_raw = run && (phase_q >= PH_RISE) && (phase_q < PH_FALL);
  assign bit_end  = run && (phase_q == PH_LAST);

  AST_PULSE_INSIDE_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk_raw) |-> $past(run)) else $error("sclk rose outside frame"); // R9
endmodule

// File: rtl/adc_frame_shifter.sv
module adc_frame_shifter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_data,
  input  logic         bit_end,
  output logic         active,
  output logic         msb,
  output logic         frame_done
);
  localparam int BIT_W = $clog2(W);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(W - 1);

  logic [W-1:0]     shreg_q, shreg_n;
  logic [BIT_W-1:0] cnt_q, cnt_n;
  logic             active_q, active_n;
  logic             step;

  assign step       = active_q && bit_end;
  assign frame_done = step && (cnt_q == LAST_BIT);

  always_comb begin
    shreg_n  = shreg_q;
    cnt_n    = cnt_q;
    active_n = active_q;
    if (load) begin
      shreg_n  = load_data;
      cnt_n    = '0;
      active_n = 1'b1;
    end else if (step) begin
      shreg_n = {shreg_q[W-2:0], 1'b0};
      cnt_n   = cnt_q + 1'b1;
      if (cnt_q == LAST_BIT) active_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg_q  <= '0;
      cnt_q    <= '0;
      active_q <= 1'b0;
    end else if (load || step) begin
      shreg_q  <= shreg_n;
      cnt_q    <= cnt_n;
      active_q <= active_n;
    end
  end

  assign active = active_q;
  assign msb    = shreg_q[W-1];

  AST_NO_LOAD_MIDFRAME: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !active_q) else $error("frame reloaded while running"); // R2
  AST_BIT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    active_q && !bit_end |=> $stable(shreg_q)) else $error("bit changed mid-window"); // R6
  AST_FRAME_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(active_q) |-> $past(cnt_q) == LAST_BIT) else $error("frame length wrong"); // R5
endmodule

// File: rtl/adc_conv_ctrl.sv
module adc_conv_ctrl
  import adc_ser_pkg::*;
#(
  parameter int W           = 16,
  parameter int CONV_CYCLES = 100
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         mode,
  input  logic [W-1:0] sample_data,
  input  logic         frame_done,
  output logic         busy,
  output logic         load_frame,
  output logic [W-1:0] load_data,
  output logic         conv_end,
  output logic         mode_held
);
  localparam int CNT_W = $clog2(CONV_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(CONV_CYCLES - 1);

  ctl_state_e       state_q, state_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             mode_q, mode_n;
  logic [W-1:0]     result_q;

  always_comb begin
    state_n    = state_q;
    cnt_n      = cnt_q;
    mode_n     = mode_q;
    load_frame = 1'b0;
    conv_end   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_n    = ST_CONV;
          cnt_n      = CNT_LOAD;
          mode_n     = mode;
          load_frame = mode;
        end
      end
      ST_CONV: begin
        if (cnt_q == '0) begin
          conv_end = 1'b1;
          if (mode_q) begin
            state_n = ST_IDLE;
          end else begin
            state_n    = ST_SHIFT;
            load_frame = 1'b1;
          end
        end else begin
          cnt_n = cnt_q - 1'b1;
        end
      end
      ST_SHIFT: begin
        if (frame_done) state_n = ST_IDLE;
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      mode_q  <= 1'b0;
    end else begin
      state_q <= state_n;
      cnt_q   <= cnt_n;
      mode_q  <= mode_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        result_q <= '0;
    else if (conv_end) result_q <= sample_data;
  end

  assign busy      = (state_q != ST_IDLE);
  assign load_data = (state_q == ST_IDLE) ? result_q : sample_data;
  assign mode_held = mode_q;

  AST_START_RAISES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy |=> busy) else $error("start not accepted"); // R1
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    start && state_q == ST_CONV && cnt_q != '0 |=> cnt_q == $past(cnt_q) - 1'b1 && mode_q == $past(mode_q))
    else $error("start accepted while busy"); // R2
  AST_SHIFT_HOLDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == ST_SHIFT && !frame_done |=> busy) else $error("busy fell before last bit"); // R3
  AST_RESULT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !conv_end |=> $stable(result_q)) else $error("result changed outside capture"); // R10
endmodule

// File: rtl/adc_serial_master.sv
module adc_serial_master #(
  parameter int W           = 16,
  parameter int QTR         = 1,
  parameter int CONV_CYCLES = 100
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         conv_start,
  input  logic [W-1:0] sample_data,
  input  logic         read_mode,
  input  logic         sclk_inv,
  input  logic         sync_inv,
  output logic         busy,
  output logic         sclk,
  output logic         sync,
  output logic         sdout
);
  logic         rst_n_s;
  logic         load_frame;
  logic [W-1:0] load_data;
  logic         conv_end;
  logic         mode_held;
  logic         frame_active;
  logic         frame_msb;
  logic         frame_done;
  logic         sclk_raw;
  logic         bit_end;

  adc_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  adc_conv_ctrl #(.W(W), .CONV_CYCLES(CONV_CYCLES)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .start       (conv_start),
    .mode        (read_mode),
    .sample_data (sample_data),
    .frame_done  (frame_done),
    .busy        (busy),
    .load_frame  (load_frame),
    .load_data   (load_data),
    .conv_end    (conv_end),
    .mode_held   (mode_held)
  );

  adc_sclk_gen #(.QTR(QTR)) u_sclk (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .run      (frame_active),
    .restart  (load_frame),
    .sclk_raw (sclk_raw),
    .bit_end  (bit_end)
  );

  adc_frame_shifter #(.W(W)) u_shift (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .load       (load_frame),
    .load_data  (load_data),
    .bit_end    (bit_end),
    .active     (frame_active),
    .msb        (frame_msb),
    .frame_done (frame_done)
  );

  assign sclk  = sclk_raw ^ sclk_inv;
  assign sync  = frame_active ^ sync_inv;
  assign sdout = frame_active & frame_msb;

  AST_FRAME_FITS_CONV: assert property (@(posedge clk) disable iff (!rst_n_s)
    conv_end && mode_held |-> !frame_active) else $error("frame overran conversion"); // R4
  AST_FRAME_UNDER_BUSY: assert property (@(posedge clk) disable iff (!rst_n_s)
    frame_active |-> busy) else $error("frame outside busy"); // R7
  AST_IDLE_DATA_LOW: assert property (@(posedge clk) disable iff (!rst_n_s)
    !frame_active |-> !sdout && !sclk_raw) else $error("line active outside frame"); // R9
endmodule

// File: tb/adc_serial_master_bench.sv
module adc_serial_master_bench;
  localparam int W     = 16;
  localparam int QTR   = 1;
  localparam int CONV  = 100;
  localparam int FRAME = 16 * 4 * QTR;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         conv_start;
  logic [W-1:0] sample_data;
  logic         read_mode;
  logic         sclk_inv;
  logic         sync_inv;
  logic         busy, sclk, sync, sdout;

  int total = 0;
  int bad   = 0;
  logic [W-1:0] exp_q[$];
  logic [W-1:0] last_word;
  int           frames_seen = 0;

  always #2 clk = ~clk;

  adc_serial_master #(.W(W), .QTR(QTR), .CONV_CYCLES(CONV)) u_adc_serial_master (
    .clk(clk), .rst_n(rst_n), .conv_start(conv_start), .sample_data(sample_data),
    .read_mode(read_mode), .sclk_inv(sclk_inv), .sync_inv(sync_inv),
    .busy(busy), .sclk(sclk), .sync(sync), .sdout(sdout)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: decodes frames at the pins and scores them
  logic         mon_on = 1'b0;
  logic         raw_s, act_s, raw_prev, act_prev;
  logic         held_bit;
  logic [W-1:0] cap;
  int           rises;

  always @(negedge clk) begin
    if (mon_on) begin
      raw_s = sclk ^ sclk_inv;
      act_s = sync ^ sync_inv;
      if (act_s) begin
        if (!busy) chk(1'b0, "R7 frame outside busy", 32'(busy), 32'd1);
        if (raw_s && !raw_prev) begin
          cap      = {cap[W-2:0], sdout};
          held_bit = sdout;
          rises++;
        end
        if (!raw_s && raw_prev)
          chk(sdout == held_bit, "R6 data moved between edges", 32'(sdout), 32'(held_bit));
      end else begin
        if (act_prev) begin
          frames_seen++;
          chk(rises == 16, "R5 pulse count", 32'(rises), 32'd16);
          if (exp_q.size() == 0) begin
            chk(1'b0, "R5 unexpected frame", 32'(cap), 32'd0);
          end else begin
            logic [W-1:0] e;
            e = exp_q.pop_front();
            chk(cap == e, "R3 R4 R10 frame word", 32'(cap), 32'(e));
          end
        end
        if (sdout != 1'b0 || raw_s != 1'b0)
          chk(1'b0, "R9 idle levels", {30'd0, sdout, raw_s}, 32'd0);
        rises = 0;
      end
      raw_prev = raw_s;
      act_prev = act_s;
    end
  end

  task automatic do_conv(input logic m, input logic [W-1:0] word, input bit poke);
    int cnt;
    int exp_w;
    @(posedge clk); #1;
    read_mode   = m;
    sample_data = word;
    conv_start  = 1'b1;
    exp_q.push_back(m ? last_word : word);
    last_word   = word;
    @(posedge clk); #1;
    conv_start  = 1'b0;
    @(negedge clk);
    chk(busy == 1'b1, "R1 busy after start", 32'(busy), 32'd1);
    cnt = 0;
    while (busy) begin
      cnt++;
      if (poke && cnt == 10) begin
        conv_start = 1'b1;
        read_mode  = ~m;
        sample_data = ~word;
      end
      if (poke && cnt == 11) begin
        conv_start  = 1'b0;
        read_mode   = m;
        sample_data = word;
      end
      if (!m && cnt == CONV + 1) sample_data = ~word;  // R10 scramble after capture
      @(negedge clk);
    end
    sample_data = ~word;                                 // R10 scramble after capture
    exp_w = m ? CONV : CONV + FRAME;
    chk(cnt == exp_w, m ? "R4 R2 busy length" : "R3 R2 busy length", 32'(cnt), 32'(exp_w));
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #(200000 * 4);
    chk(1'b0, "watchdog expired", 32'd0, 32'd1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; conv_start = 1'b0; sample_data = '0; read_mode = 1'b0;
    sclk_inv = 1'b0; sync_inv = 1'b0; last_word = '0;
    raw_prev = 1'b0; act_prev = 1'b0; rises = 0; cap = '0; held_bit = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(busy == 1'b0, "R11 reset busy", 32'(busy), 32'd0);
    chk(sdout == 1'b0, "R11 reset sdout", 32'(sdout), 32'd0);
    chk(sync == 1'b0, "R11 reset sync", 32'(sync), 32'd0);
    chk(sclk == 1'b0, "R11 reset sclk", 32'(sclk), 32'd0);
    mon_on = 1'b1;

    do_conv(1'b1, 16'h3C5A, 1'b0);   // R4 first mode-1 frame carries reset value 0
    do_conv(1'b0, 16'hA5C3, 1'b1);   // R3 with ignored start (R2)
    do_conv(1'b0, 16'h8001, 1'b0);
    do_conv(1'b1, 16'h1234, 1'b1);   // R4 with ignored start (R2)
    do_conv(1'b1, 16'hFFFF, 1'b0);

    @(posedge clk); #1; sclk_inv = 1'b1; sync_inv = 1'b1;
    @(negedge clk);
    chk(sclk == 1'b1, "R8 inverted idle sclk", 32'(sclk), 32'd1);
    chk(sync == 1'b1, "R8 inverted idle sync", 32'(sync), 32'd1);
    chk(sdout == 1'b0, "R9 idle sdout inverted", 32'(sdout), 32'd0);
    do_conv(1'b0, 16'h0F0F, 1'b0);   // R8
    do_conv(1'b1, 16'h7E81, 1'b1);   // R8
    @(posedge clk); #1; sclk_inv = 1'b0; sync_inv = 1'b0;

    do_conv(1'b0, 16'h0000, 1'b0);
    do_conv(1'b1, 16'hC001, 1'b0);
    repeat (10) @(negedge clk);
    chk(exp_q.size() == 0, "R5 frames missing", 32'(exp_q.size()), 32'd0);
    chk(frames_seen == 9, "R5 frame count", 32'(frames_seen), 32'd9);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule